// File: doc/BRIEF.md
# Bank-Mapping Memory Management Unit

This block sits between a small processor core and its internal memories and turns each 16-bit logical address into a physical bank number plus an in-bank offset. The top four address bits pick one of sixteen logical banks. Each bank has a table entry that gives a physical bank number, a ROM/RAM target select, and five status bits: not-present, accessed, supervisor-only, write-protect and execute-protect. Every access is classed as a read, an instruction fetch or a write. It is checked against the entry and the current privilege. A violating access is reported as a bank fault with a three-bit type code, and it reaches no memory.

When mapping is switched off, as happens on interrupt entry, the table is bypassed. A fixed map applies: logical bank n goes to internal RAM bank n, except that bank 0 goes to internal ROM bank 0 unless the RAM-at-zero input is high. The table keeps its contents while mapping is off, so switching mapping back on restores the earlier address space. Software saves or restores the whole table through a 32-word port, for example on a context switch.

Results are registered. The strobes, the fault indication, the code and the physical address appear in the cycle after the access is presented.

Top module: `bank_mmu`

## Requirements
- R1: After reset the outputs `mem_rd_o`, `mem_wr_o` and `fault_o` are low. Every entry holds physical bank number equal to its own index, ROM select clear and all five status bits clear.
- R2: With `map_en_i` low, no fault is raised. Bank 0 targets ROM bank 0 when `ram_at_zero_i` is low and RAM bank 0 when it is high. Banks 1 to 15 target RAM bank with the same number. The table is ignored.
- R3: With `map_en_i` high, a permitted access drives `phys_bank_o` from the entry's bank number and `phys_rom_o` from its ROM select. `phys_ofs_o` carries the low 12 address bits unchanged. `mem_rd_o` pulses for reads and fetches, and `mem_wr_o` pulses for writes. All of these appear one cycle after `acc_valid_i`.
- R4: A mapped access to an entry with the not-present bit set faults with code 3'b000. This check takes priority over every protection check.
- R5: A mapped user-mode access to an entry with the supervisor-only bit set faults with code 3'b100 for a read or fetch and 3'b110 for a write. This ranks below R4 and above R6 and R7.
- R6: A mapped fetch (`acc_exec_i` high, `acc_write_i` low) of an entry with execute-protect set faults with code 3'b001. When `acc_write_i` is high, the access is a write regardless of `acc_exec_i`.
- R7: A mapped write to an entry with write-protect set faults with code 3'b010. This holds for RAM and ROM targets and for both privileges.
- R8: A faulting access produces no `mem_rd_o` or `mem_wr_o` pulse. It leaves the accessed bit unchanged. `fault_o` pulses for exactly the cycle the result appears.
- R9: A mapped write that is issued to RAM sets the entry's accessed bit. Reads, fetches, faulting writes and dropped writes leave it as it was.
- R10: A write whose target is ROM and which does not fault is dropped silently: no strobe and no fault. This covers every unmapped write to ROM bank 0 and mapped writes to ROM entries whose write-protect bit is clear.
- R11: Table word 2n is entry n's first word: bank number in bits 7:0 and ROM select in bit 15. Table word 2n+1 is its status word: execute-protect bit 0, write-protect bit 1, supervisor-only bit 2, accessed bit 3, not-present bit 4. Unused bits read back as zero.
- R12: If a table write to an entry's status word and an access that sets that entry's accessed bit fall in the same cycle, the written word is what remains. The access itself is judged against the entry's contents from before that cycle.
- R13: Toggling `map_en_i` does not alter any table word. After mapping is re-enabled, translation and checks follow the table as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_en_i | input | 1 | Table mapping enabled |
| ram_at_zero_i | input | 1 | Unmapped bank 0 targets RAM instead of ROM |
| user_mode_i | input | 1 | Access made in user mode |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_write_i | input | 1 | Access is a write |
| acc_exec_i | input | 1 | Access is an instruction fetch |
| acc_addr_i | input | 16 | Logical address |
| tbl_we_i | input | 1 | Table word write enable |
| tbl_widx_i | input | 5 | Table word write index |
| tbl_wdata_i | input | 16 | Table word write data |
| tbl_ridx_i | input | 5 | Table word read index |
| tbl_rdata_o | output | 16 | Table word read data (combinational) |
| phys_bank_o | output | 8 | Physical bank number |
| phys_rom_o | output | 1 | Target is ROM |
| phys_ofs_o | output | 12 | Offset within bank |
| mem_rd_o | output | 1 | Read or fetch strobe |
| mem_wr_o | output | 1 | Write strobe |
| fault_o | output | 1 | Bank fault |
| fault_code_o | output | 3 | Fault type code |

## Verification
A table write to an entry's status word and a RAM write through that same entry can land on one clock edge. The first drives the accessed bit from the word port, and the second sets it from the access path. The bench provokes this by asserting `tbl_we_i` on word 25 in the very cycle it issues a supervisor write to bank 12. It judges two things: the access outcome must follow the pre-edge entry, and the word read back afterwards must equal the written value with the accessed bit as written. A follow-up user read of bank 12 confirms that the newly written supervisor-only bit took effect.

// File: rtl/bank_mmu_pkg.sv
package bank_mmu_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned ROM_BIT = WORD_W - 1;

  // status word layout, bit 4 down to bit 0
  typedef struct packed {
    logic np;   // not present
    logic acc;  // accessed
    logic sup;  // supervisor only
    logic wp;   // write protect
    logic xp;   // execute protect
  } flags_t;

  localparam int unsigned FLAGS_W = $bits(flags_t);

  typedef enum logic [2:0] {
    FLT_ABSENT = 3'b000,
    FLT_XPROT  = 3'b001,
    FLT_WPROT  = 3'b010,
    FLT_USR_RD = 3'b100,
    FLT_USR_WR = 3'b110
  } fault_e;
endpackage

// File: rtl/bank_mmu_table.sv
module bank_mmu_table
  import bank_mmu_pkg::*;
#(
  parameter int unsigned BANK_BITS = 4,
  parameter int unsigned PBANK_W   = 8,
  localparam int unsigned NUM_BANKS = 1 << BANK_BITS,
  localparam int unsigned IDX_W     = BANK_BITS + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BANK_BITS-1:0] lk_bank_i,
  output logic [PBANK_W-1:0]   lk_pbank_o,
  output logic                 lk_rom_o,
  output logic                 lk_np_o,
  output logic                 lk_sup_o,
  output logic                 lk_wp_o,
  output logic                 lk_xp_o,
  input  logic                 set_acc_i,
  input  logic [BANK_BITS-1:0] set_bank_i,
  input  logic                 tw_en_i,
  input  logic [IDX_W-1:0]     tw_idx_i,
  input  logic [WORD_W-1:0]    tw_data_i,
  input  logic [IDX_W-1:0]     tr_idx_i,
  output logic [WORD_W-1:0]    tr_data_o
);
  logic [PBANK_W-1:0] pbank_q [NUM_BANKS];
  logic               rom_q   [NUM_BANKS];
  flags_t             flg_q   [NUM_BANKS];

  logic [BANK_BITS-1:0] tw_bank, tr_bank;
  logic                 tw_hi, tr_hi;
  assign tw_bank = tw_idx_i[IDX_W-1:1];
  assign tw_hi   = tw_idx_i[0];
  assign tr_bank = tr_idx_i[IDX_W-1:1];
  assign tr_hi   = tr_idx_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        pbank_q[b] <= PBANK_W'(b);
        rom_q[b]   <= 1'b0;
        flg_q[b]   <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (tw_en_i && !tw_hi && tw_bank == BANK_BITS'(b)) begin
          pbank_q[b] <= tw_data_i[PBANK_W-1:0];
          rom_q[b]   <= tw_data_i[ROM_BIT];
        end
        // word port wins over the access path
        if (tw_en_i && tw_hi && tw_bank == BANK_BITS'(b))
          flg_q[b] <= flags_t'(tw_data_i[FLAGS_W-1:0]);
        else if (set_acc_i && set_bank_i == BANK_BITS'(b))
          flg_q[b].acc <= 1'b1;
      end
    end
  end

  assign lk_pbank_o = pbank_q[lk_bank_i];
  assign lk_rom_o   = rom_q[lk_bank_i];
  assign lk_np_o    = flg_q[lk_bank_i].np;
  assign lk_sup_o   = flg_q[lk_bank_i].sup;
  assign lk_wp_o    = flg_q[lk_bank_i].wp;
  assign lk_xp_o    = flg_q[lk_bank_i].xp;

  always_comb begin
    tr_data_o = '0;
    if (tr_hi) begin
      tr_data_o[FLAGS_W-1:0] = flg_q[tr_bank];
    end else begin
      tr_data_o[PBANK_W-1:0] = pbank_q[tr_bank];
      tr_data_o[ROM_BIT]     = rom_q[tr_bank];
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
    assert_acc_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flg_q[g].acc) |->
        $past(set_acc_i && set_bank_i == BANK_BITS'(g)) ||
        $past(tw_en_i && tw_hi && tw_bank == BANK_BITS'(g)));
    assert_word_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tw_en_i && tw_hi && tw_bank == BANK_BITS'(g) && set_acc_i && set_bank_i == BANK_BITS'(g))
        |=> flg_q[g].acc == $past(tw_data_i[3]));
  end
endmodule

// File: rtl/bank_mmu_check.sv
module bank_mmu_check
  import bank_mmu_pkg::*;
#(
  parameter int unsigned BANK_BITS = 4,
  parameter int unsigned PBANK_W   = 8
) (
  input  logic                 map_en_i,
  input  logic                 ram_at_zero_i,
  input  logic                 user_i,
  input  logic                 write_i,
  input  logic                 exec_i,
  input  logic [BANK_BITS-1:0] bank_i,
  input  logic [PBANK_W-1:0]   lk_pbank_i,
  input  logic                 lk_rom_i,
  input  logic                 lk_np_i,
  input  logic                 lk_sup_i,
  input  logic                 lk_wp_i,
  input  logic                 lk_xp_i,
  output logic [PBANK_W-1:0]   tgt_pbank_o,
  output logic                 tgt_rom_o,
  output logic                 fault_o,
  output fault_e               code_o,
  output logic                 do_rd_o,
  output logic                 do_wr_o,
  output logic                 set_acc_o
);
  always_comb begin
    tgt_pbank_o = PBANK_W'(bank_i);
    tgt_rom_o   = (bank_i == '0) && !ram_at_zero_i;
    fault_o     = 1'b0;
    code_o      = FLT_ABSENT;
    if (map_en_i) begin
      tgt_pbank_o = lk_pbank_i;
      tgt_rom_o   = lk_rom_i;
      // priority: absent, privilege, execute, write
      if (lk_np_i) begin
        fault_o = 1'b1;
        code_o  = FLT_ABSENT;
      end else if (user_i && lk_sup_i) begin
        fault_o = 1'b1;
        code_o  = write_i ? FLT_USR_WR : FLT_USR_RD;
      end else if (!write_i && exec_i && lk_xp_i) begin
        fault_o = 1'b1;
        code_o  = FLT_XPROT;
      end else if (write_i && lk_wp_i) begin
        fault_o = 1'b1;
        code_o  = FLT_WPROT;
      end
    end
    do_rd_o   = !write_i && !fault_o;
    do_wr_o   = write_i && !fault_o && !tgt_rom_o;
    set_acc_o = do_wr_o && map_en_i;
  end
endmodule

// File: rtl/bank_mmu_resp.sv
module bank_mmu_resp
  import bank_mmu_pkg::*;
#(
  parameter int unsigned PBANK_W = 8,
  parameter int unsigned OFS_W   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [PBANK_W-1:0] pbank_i,
  input  logic               rom_i,
  input  logic [OFS_W-1:0]   ofs_i,
  input  logic               do_rd_i,
  input  logic               do_wr_i,
  input  logic               fault_i,
  input  fault_e             code_i,
  output logic [PBANK_W-1:0] pbank_o,
  output logic               rom_o,
  output logic [OFS_W-1:0]   ofs_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic               fault_o,
  output logic [2:0]         code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pbank_o <= '0;
      rom_o   <= 1'b0;
      ofs_o   <= '0;
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      fault_o <= 1'b0;
      code_o  <= '0;
    end else begin
      rd_o    <= valid_i && do_rd_i;
      wr_o    <= valid_i && do_wr_i;
      fault_o <= valid_i && fault_i;
      if (valid_i) begin
        pbank_o <= pbank_i;
        rom_o   <= rom_i;
        ofs_o   <= ofs_i;
        code_o  <= code_i;
      end
    end
  end

  assert_fault_no_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_o, wr_o, fault_o}));
  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i) |=> !rd_o && !wr_o && !fault_o);
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
  import bank_mmu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BANK_BITS = 4,
  parameter int unsigned PBANK_W   = 8,
  localparam int unsigned IDX_W    = BANK_BITS + 1,
  localparam int unsigned OFS_W    = ADDR_W - BANK_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 map_en_i,
  input  logic                 ram_at_zero_i,
  input  logic                 user_mode_i,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic                 acc_exec_i,
  input  logic [ADDR_W-1:0]    acc_addr_i,
  input  logic                 tbl_we_i,
  input  logic [IDX_W-1:0]     tbl_widx_i,
  input  logic [WORD_W-1:0]    tbl_wdata_i,
  input  logic [IDX_W-1:0]     tbl_ridx_i,
  output logic [WORD_W-1:0]    tbl_rdata_o,
  output logic [PBANK_W-1:0]   phys_bank_o,
  output logic                 phys_rom_o,
  output logic [OFS_W-1:0]     phys_ofs_o,
  output logic                 mem_rd_o,
  output logic                 mem_wr_o,
  output logic                 fault_o,
  output logic [2:0]           fault_code_o
);
  logic [BANK_BITS-1:0] bank;
  logic [OFS_W-1:0]     ofs;
  assign bank = acc_addr_i[ADDR_W-1:OFS_W];
  assign ofs  = acc_addr_i[OFS_W-1:0];

  logic [PBANK_W-1:0] lk_pbank, tgt_pbank;
  logic lk_rom, lk_np, lk_sup, lk_wp, lk_xp;
  logic tgt_rom, chk_fault, do_rd, do_wr, set_acc;
  fault_e chk_code;

  bank_mmu_table #(.BANK_BITS(BANK_BITS), .PBANK_W(PBANK_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_bank_i  (bank),
    .lk_pbank_o (lk_pbank),
    .lk_rom_o   (lk_rom),
    .lk_np_o    (lk_np),
    .lk_sup_o   (lk_sup),
    .lk_wp_o    (lk_wp),
    .lk_xp_o    (lk_xp),
    .set_acc_i  (acc_valid_i && set_acc),
    .set_bank_i (bank),
    .tw_en_i    (tbl_we_i),
    .tw_idx_i   (tbl_widx_i),
    .tw_data_i  (tbl_wdata_i),
    .tr_idx_i   (tbl_ridx_i),
    .tr_data_o  (tbl_rdata_o)
  );

  bank_mmu_check #(.BANK_BITS(BANK_BITS), .PBANK_W(PBANK_W)) u_check (
    .map_en_i      (map_en_i),
    .ram_at_zero_i (ram_at_zero_i),
    .user_i        (user_mode_i),
    .write_i       (acc_write_i),
    .exec_i        (acc_exec_i),
    .bank_i        (bank),
    .lk_pbank_i    (lk_pbank),
    .lk_rom_i      (lk_rom),
    .lk_np_i       (lk_np),
    .lk_sup_i      (lk_sup),
    .lk_wp_i       (lk_wp),
    .lk_xp_i       (lk_xp),
    .tgt_pbank_o   (tgt_pbank),
    .tgt_rom_o     (tgt_rom),
    .fault_o       (chk_fault),
    .code_o        (chk_code),
    .do_rd_o       (do_rd),
    .do_wr_o       (do_wr),
    .set_acc_o     (set_acc)
  );

  bank_mmu_resp #(.PBANK_W(PBANK_W), .OFS_W(OFS_W)) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (acc_valid_i),
    .pbank_i (tgt_pbank),
    .rom_i   (tgt_rom),
    .ofs_i   (ofs),
    .do_rd_i (do_rd),
    .do_wr_i (do_wr),
    .fault_i (chk_fault),
    .code_i  (chk_code),
    .pbank_o (phys_bank_o),
    .rom_o   (phys_rom_o),
    .ofs_o   (phys_ofs_o),
    .rd_o    (mem_rd_o),
    .wr_o    (mem_wr_o),
    .fault_o (fault_o),
    .code_o  (fault_code_o)
  );

  assert_unmapped_nofault_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !map_en_i) |=> !fault_o);
  assert_rom_write_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && !map_en_i && bank == '0 && !ram_at_zero_i)
      |=> !mem_wr_o && !fault_o);
  assert_absent_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && map_en_i && lk_np) |=> fault_o && fault_code_o == 3'b000);
  assert_offset_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> phys_ofs_o == $past(ofs));
endmodule

// File: tb/tb_bank_mmu.sv
module tb_bank_mmu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic map_en = 0, ram0 = 0, user = 0, valid = 0, wr = 0, ex = 0;
  logic [15:0] addr = '0;
  logic tbl_we = 0;
  logic [4:0] widx = '0, ridx = '0;
  logic [15:0] wdata = '0, rdata;
  logic [7:0] pbank;
  logic prom, mrd, mwr, flt;
  logic [11:0] pofs;
  logic [2:0] fcode;

  bank_mmu dut (
    .clk_i(clk), .rst_ni(rst_n), .map_en_i(map_en), .ram_at_zero_i(ram0),
    .user_mode_i(user), .acc_valid_i(valid), .acc_write_i(wr), .acc_exec_i(ex),
    .acc_addr_i(addr), .tbl_we_i(tbl_we), .tbl_widx_i(widx), .tbl_wdata_i(wdata),
    .tbl_ridx_i(ridx), .tbl_rdata_o(rdata), .phys_bank_o(pbank), .phys_rom_o(prom),
    .phys_ofs_o(pofs), .mem_rd_o(mrd), .mem_wr_o(mwr), .fault_o(flt),
    .fault_code_o(fcode)
  );

  typedef struct {
    logic rd, wr, flt;
    logic [2:0] code;
    logic [7:0] pb;
    logic rom;
    logic [11:0] ofs;
    string req;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0;
  bit done = 0;

  // independent model of the table
  logic [7:0] m_pb [16];
  logic       m_rom [16];
  logic [4:0] m_fl [16];   // {np,acc,sup,wp,xp}

  task automatic model_wr(input logic [4:0] idx, input logic [15:0] d);
    if (idx[0]) m_fl[idx[4:1]] = d[4:0];
    else begin m_pb[idx[4:1]] = d[7:0]; m_rom[idx[4:1]] = d[15]; end
  endtask

  function automatic logic [15:0] model_rd(input logic [4:0] idx);
    if (idx[0]) return {11'b0, m_fl[idx[4:1]]};
    return {m_rom[idx[4:1]], 7'b0, m_pb[idx[4:1]]};
  endfunction

  function automatic exp_t predict(input logic m, r, u, w, x, input logic [15:0] a, input string req);
    exp_t e;
    logic [3:0] b = a[15:12];
    e.req = req; e.ofs = a[11:0]; e.flt = 0; e.code = 3'b000;
    if (!m) begin
      e.pb = {4'b0, b}; e.rom = (b == 0) && !r;
    end else begin
      e.pb = m_pb[b]; e.rom = m_rom[b];
      if (m_fl[b][4]) begin e.flt = 1; e.code = 3'b000; end
      else if (u && m_fl[b][2]) begin e.flt = 1; e.code = w ? 3'b110 : 3'b100; end
      else if (!w && x && m_fl[b][0]) begin e.flt = 1; e.code = 3'b001; end
      else if (w && m_fl[b][1]) begin e.flt = 1; e.code = 3'b010; end
    end
    e.rd = !w && !e.flt;
    e.wr = w && !e.flt && !e.rom;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input logic [31:0] act, exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  task automatic acc(input logic m, r, u, w, x, input logic [15:0] a, input string req);
    exp_t e;
    @(negedge clk);
    tbl_we = 0;
    map_en = m; ram0 = r; user = u; wr = w; ex = x; addr = a; valid = 1;
    e = predict(m, r, u, w, x, a, req);
    q.push_back(e);
    if (e.wr && m) m_fl[a[15:12]][3] = 1'b1;
  endtask

  task automatic twr(input logic [4:0] idx, input logic [15:0] d);
    @(negedge clk);
    valid = 0; tbl_we = 1; widx = idx; wdata = d;
    model_wr(idx, d);
  endtask

  // access and table word write in the same cycle
  task automatic collide(input logic [15:0] a, input logic [4:0] idx, input logic [15:0] d, input string req);
    exp_t e;
    @(negedge clk);
    map_en = 1; ram0 = 0; user = 0; wr = 1; ex = 0; addr = a; valid = 1;
    tbl_we = 1; widx = idx; wdata = d;
    e = predict(1, 0, 0, 1, 0, a, req);
    q.push_back(e);
    if (e.wr) m_fl[a[15:12]][3] = 1'b1;
    model_wr(idx, d);
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 0; tbl_we = 0;
  endtask

  task automatic rchk(input logic [4:0] idx, input string req);
    @(negedge clk);
    valid = 0; tbl_we = 0; ridx = idx;
    #1;
    check(rdata === model_rd(idx), req, $sformatf("table word %0d", idx), rdata, model_rd(idx));
  endtask

  // monitor: pops one expected item per accepted access
  always begin
    logic v;
    exp_t e;
    @(posedge clk);
    v = valid && rst_n;
    #2;
    if (v) begin
      if (q.size() == 0) check(0, "R3", "unexpected result", 0, 1);
      else begin
        e = q.pop_front();
        check(mrd === e.rd && mwr === e.wr && flt === e.flt, e.req, "rd/wr/fault",
              {mrd, mwr, flt}, {e.rd, e.wr, e.flt});
        if (e.flt) check(fcode === e.code, e.req, "fault code", fcode, e.code);
        if (e.rd || e.wr)
          check(pbank === e.pb && prom === e.rom && pofs === e.ofs, e.req, "phys addr",
                {prom, pbank, pofs}, {e.rom, e.pb, e.ofs});
      end
    end else if (rst_n && !done) begin
      check(!mrd && !mwr && !flt, "R8", "idle strobes", {mrd, mwr, flt}, 0);
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 16; b++) begin m_pb[b] = 8'(b); m_rom[b] = 0; m_fl[b] = '0; end
    #3;
    check(!mrd && !mwr && !flt, "R1", "reset outputs", {mrd, mwr, flt}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 32; i++) rchk(5'(i), "R1");

    // unmapped map
    acc(0, 0, 0, 0, 0, 16'h0123, "R2");
    acc(0, 1, 0, 0, 0, 16'h0456, "R2");
    acc(0, 0, 1, 0, 1, 16'h5ABC, "R2");
    acc(0, 0, 0, 1, 0, 16'h0010, "R10");
    acc(0, 1, 0, 1, 0, 16'h0020, "R2");
    acc(0, 0, 1, 1, 0, 16'hF0FF, "R2");
    idle();

    // bulk load: phys 0x40+b, plus protection pattern
    for (int b = 0; b < 16; b++) begin
      twr(5'(2*b), 16'h0040 + 16'(b));
      twr(5'(2*b+1), 16'h0000);
    end
    twr(5'd2,  16'h0000); twr(5'd3,  16'h0010);          // bank1 absent
    twr(5'd5,  16'h0004);                                 // bank2 supervisor only
    twr(5'd6,  16'h8043); twr(5'd7,  16'h0002);          // bank3 ROM, write protect
    twr(5'd9,  16'h0001);                                 // bank4 exec protect
    twr(5'd11, 16'h0017);                                 // bank5 all set
    twr(5'd13, 16'h0006);                                 // bank6 sup + wp
    twr(5'd15, 16'h0002);                                 // bank7 write protect
    twr(5'd17, 16'h0003);                                 // bank8 exec + wp
    twr(5'd18, 16'hFFFF); twr(5'd19, 16'hFFE0);          // bank9 ROM, unused bits set
    idle();
    for (int i = 0; i < 32; i++) rchk(5'(i), "R11");

    acc(1, 0, 0, 0, 0, 16'hA123, "R3");
    acc(1, 0, 1, 0, 1, 16'hB456, "R3");
    acc(1, 0, 0, 1, 0, 16'hC789, "R3");
    acc(1, 0, 0, 0, 0, 16'h1000, "R4");
    acc(1, 0, 1, 1, 1, 16'h5000, "R4");
    acc(1, 0, 1, 0, 0, 16'h2001, "R5");
    acc(1, 0, 1, 1, 0, 16'h2002, "R5");
    acc(1, 0, 0, 1, 0, 16'h2003, "R5");
    acc(1, 0, 1, 0, 1, 16'h6004, "R5");
    acc(1, 0, 1, 1, 0, 16'h6005, "R5");
    acc(1, 0, 0, 0, 1, 16'h4006, "R6");
    acc(1, 0, 0, 0, 0, 16'h4007, "R6");
    acc(1, 0, 0, 1, 1, 16'h4008, "R6");
    acc(1, 0, 0, 0, 1, 16'h8009, "R6");
    acc(1, 0, 0, 1, 1, 16'h800A, "R7");
    acc(1, 0, 1, 1, 0, 16'h700B, "R7");
    acc(1, 0, 0, 1, 0, 16'h300C, "R7");
    acc(1, 0, 0, 1, 0, 16'h900D, "R10");
    acc(1, 0, 0, 0, 0, 16'h900E, "R10");
    idle();
    // accessed bits: bank10 written, bank11 read, bank7 fault, bank9 dropped
    acc(1, 0, 0, 1, 0, 16'hA000, "R9");
    acc(1, 0, 0, 0, 0, 16'hB000, "R9");
    acc(1, 0, 0, 1, 0, 16'h7000, "R8");
    acc(1, 0, 0, 1, 0, 16'h9000, "R9");
    idle();
    rchk(5'd21, "R9"); rchk(5'd23, "R9"); rchk(5'd15, "R8"); rchk(5'd19, "R9");
    rchk(5'd25, "R9");

    // same-cycle table write and accessed-bit set on bank12
    collide(16'hC321, 5'd25, 16'h0004, "R12");
    idle();
    rchk(5'd25, "R12");
    acc(1, 0, 1, 0, 0, 16'hC000, "R12");
    idle();

    // mapping off then on
    acc(0, 1, 0, 0, 0, 16'h1111, "R13");
    acc(0, 1, 1, 1, 0, 16'h2222, "R13");
    idle();
    for (int i = 0; i < 32; i++) rchk(5'(i), "R13");
    acc(1, 0, 0, 0, 0, 16'h1111, "R13");
    acc(1, 0, 0, 0, 0, 16'hA333, "R13");
    idle();
    idle();
    done = 1;
    check(q.size() == 0, "R3", "pending results", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule